// File: doc/BRIEF.md
# Windowed Register File with Save/Restore Rotation

This block is a 32-bit register file in which a procedure sees 32 logical registers, but only eight of them (the globals) are the same for every procedure. The other 24 come from a window of a larger physical array, chosen by a rotating window pointer. Each window has eight private locals. It also has two groups of eight registers that it shares with its neighbours on either side. The outgoing group of a caller is the same storage as the incoming group of the procedure it calls, so arguments pass without any copying.

A save request moves the pointer down by one, modulo the window count, to open a window for a callee. A restore request moves it back up. An eight-bit invalid-window mask guards both moves. When the target window is marked invalid, the pointer stays where it is and a one-cycle overflow flag (on save) or underflow flag (on restore) is raised, so that a trap handler can spill or fill registers.

The file has two combinational read ports and one write port, each addressed by a 5-bit logical number. The mask can be reloaded through its own write port.

Top module: `winreg_file`

## Requirements
- R1: While rst_n is low, and after it is released, the window pointer is 0, the mask equals mask_init, both trap flags are 0 and every register reads 0.
- R2: Logical register 0 always reads 0 on both read ports, and writes to it leave it unchanged.
- R3: Logical registers 1..7 are globals: the same storage is seen in every window.
- R4: Logical registers 16..23 are locals: each window has its own eight, and they are not visible from another window.
- R5: Logical registers 8..15 (outs) of window w are the same storage as logical registers 24..31 (ins) of window w-1 mod 8. The ins of window w map to shared group (w+1) mod 8, and its outs map to shared group w.
- R6: A save whose target window (pointer-1 mod 8) has a clear mask bit sets the pointer to that target at the clock edge, so 0 goes to 7. A restore whose target (pointer+1 mod 8) is valid sets the pointer to the target, so 7 goes to 0. With no request, the pointer holds.
- R7: A save whose target window's mask bit is set leaves the pointer unchanged. trap_ovf is then 1 for exactly the one cycle after that edge.
- R8: A restore whose target window's mask bit is set leaves the pointer unchanged. trap_unf is then 1 for exactly the one cycle after that edge.
- R9: When save_req and restore_req are both high, only the save is performed.
- R10: When mask_wr_en is high, wim takes mask_wr_data at the edge. A save or restore in the same cycle is checked against mask_wr_data rather than the old mask.
- R11: A register write in the same cycle as a save or restore is mapped through the pointer value before the move.
- R12: The two read ports are combinational and independent: each returns, in the same cycle, the current contents of the register its own index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mask_init | input | 8 | Mask value loaded during reset |
| rd_a_idx | input | 5 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 5 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 5 | Logical index for the write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Request to move the pointer to the callee window |
| restore_req | input | 1 | Request to move the pointer back to the caller window |
| mask_wr_en | input | 1 | Mask load enable |
| mask_wr_data | input | 8 | New mask value |
| cwp | output | 3 | Current window pointer |
| wim | output | 8 | Current invalid-window mask |
| trap_ovf | output | 1 | One-cycle save overflow flag |
| trap_unf | output | 1 | One-cycle restore underflow flag |

## Verification
The bench targets the following corner cases, and the symptom each would show if the design got it wrong:
- Pointer wrap in both directions (0 to 7 on save, 7 to 0 on restore). A design that does not wrap would lose the caller's arguments across the boundary.
- The ins/outs overlap. Swapping the shared-group offset would make a callee read zero, or its own locals, where it expects the caller's outs.
- Blocked moves. A wrong mask check would show either a moved pointer with no trap, or a trap that lasts longer than one cycle.
- A mask load in the same cycle as a save. This checks that the new mask decides the move; a stale check would raise a spurious overflow.
- A write in the same cycle as a save. This must land in the old window; using the post-move pointer would corrupt the callee's local.
- Simultaneous save and restore. This must behave as a save.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int unsigned WR_DATA_W = 32;
  localparam int unsigned WR_NWIN   = 8;
  localparam int unsigned WR_GRP    = 8;

  typedef enum logic [1:0] {
    RGN_GLOBAL = 2'd0,
    RGN_OUT    = 2'd1,
    RGN_LOCAL  = 2'd2,
    RGN_IN     = 2'd3
  } region_e;
endpackage

// File: rtl/winreg_map.sv
module winreg_map #(
  parameter int unsigned NWIN   = 8,
  parameter int unsigned GRP    = 8,
  parameter int unsigned LIDX_W = 5,
  parameter int unsigned WIN_W  = 3,
  parameter int unsigned PIDX_W = 8
) (
  input  logic [LIDX_W-1:0] lidx,
  input  logic [WIN_W-1:0]  win,
  output logic [PIDX_W-1:0] pidx,
  output logic              is_zero
);
  import winreg_pkg::*;

  localparam int unsigned OFF_W   = $clog2(GRP);
  localparam int unsigned SH_BASE = GRP;
  localparam int unsigned LC_BASE = GRP + NWIN * GRP;

  region_e     rgn;
  logic [OFF_W-1:0] off;
  int unsigned win_up;
  int unsigned calc;

  assign rgn     = region_e'(lidx[LIDX_W-1 -: 2]);
  assign off     = lidx[OFF_W-1:0];
  assign is_zero = (lidx == '0);

  always_comb begin
    win_up = (int'(win) == NWIN - 1) ? 0 : int'(win) + 1;
    unique case (rgn)
      RGN_GLOBAL: calc = int'(off);
      RGN_OUT:    calc = SH_BASE + int'(win) * GRP + int'(off);
      RGN_LOCAL:  calc = LC_BASE + int'(win) * GRP + int'(off);
      default:    calc = SH_BASE + win_up * GRP + int'(off);
    endcase
    pidx = PIDX_W'(calc);
  end
endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl #(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NWIN-1:0]  mask_init,
  input  logic             save_req,
  input  logic             restore_req,
  input  logic             mask_wr_en,
  input  logic [NWIN-1:0]  mask_wr_data,
  output logic [WIN_W-1:0] cwp,
  output logic [NWIN-1:0]  wim,
  output logic             trap_ovf,
  output logic             trap_unf
);
  logic [WIN_W-1:0] dn_win, up_win, cwp_nx;
  logic [NWIN-1:0]  chk_mask, wim_nx;
  logic             ovf_nx, unf_nx;

  always_comb begin
    dn_win   = (cwp == '0) ? WIN_W'(NWIN - 1) : cwp - 1'b1;
    up_win   = (cwp == WIN_W'(NWIN - 1)) ? '0 : cwp + 1'b1;
    chk_mask = mask_wr_en ? mask_wr_data : wim;
    wim_nx   = mask_wr_en ? mask_wr_data : wim;
    cwp_nx   = cwp;
    ovf_nx   = 1'b0;
    unf_nx   = 1'b0;
    if (save_req) begin
      if (chk_mask[dn_win]) ovf_nx = 1'b1;
      else                  cwp_nx = dn_win;
    end else if (restore_req) begin
      if (chk_mask[up_win]) unf_nx = 1'b1;
      else                  cwp_nx = up_win;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp      <= '0;
      wim      <= mask_init;
      trap_ovf <= 1'b0;
      trap_unf <= 1'b0;
    end else begin
      cwp      <= cwp_nx;
      wim      <= wim_nx;
      trap_ovf <= ovf_nx;
      trap_unf <= unf_nx;
    end
  end
endmodule

// File: rtl/winreg_array.sv
module winreg_array #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NPHYS  = 136,
  parameter int unsigned PIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIDX_W-1:0] ra_idx,
  input  logic              ra_zero,
  output logic [DATA_W-1:0] ra_data,
  input  logic [PIDX_W-1:0] rb_idx,
  input  logic              rb_zero,
  output logic [DATA_W-1:0] rb_data,
  input  logic              we,
  input  logic [PIDX_W-1:0] w_idx,
  input  logic [DATA_W-1:0] w_data
);
  logic [DATA_W-1:0] mem [NPHYS];

  assign mem[0] = '0;

  for (genvar e = 1; e < NPHYS; e++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (w_idx == PIDX_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem[e] <= '0;
      else if (ent_en) mem[e] <= w_data;
    end
  end

  assign ra_data = ra_zero ? '0 : mem[ra_idx];
  assign rb_data = rb_zero ? '0 : mem[rb_idx];
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int unsigned DATA_W = winreg_pkg::WR_DATA_W,
  parameter int unsigned NWIN   = winreg_pkg::WR_NWIN,
  parameter int unsigned GRP    = winreg_pkg::WR_GRP,
  localparam int unsigned LIDX_W = 2 + $clog2(GRP),
  localparam int unsigned WIN_W  = $clog2(NWIN),
  localparam int unsigned NPHYS  = GRP + 2 * NWIN * GRP,
  localparam int unsigned PIDX_W = $clog2(NPHYS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NWIN-1:0]   mask_init,
  input  logic [LIDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [LIDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [LIDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              save_req,
  input  logic              restore_req,
  input  logic              mask_wr_en,
  input  logic [NWIN-1:0]   mask_wr_data,
  output logic [WIN_W-1:0]  cwp,
  output logic [NWIN-1:0]   wim,
  output logic              trap_ovf,
  output logic              trap_unf
);
  logic [PIDX_W-1:0] pa, pb, pw;
  logic              za, zb, zw;

  winreg_ctl #(.NWIN(NWIN), .WIN_W(WIN_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .mask_init(mask_init),
    .save_req(save_req), .restore_req(restore_req),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cwp(cwp), .wim(wim), .trap_ovf(trap_ovf), .trap_unf(trap_unf)
  );

  winreg_map #(.NWIN(NWIN), .GRP(GRP), .LIDX_W(LIDX_W), .WIN_W(WIN_W), .PIDX_W(PIDX_W))
    u_map_a (.lidx(rd_a_idx), .win(cwp), .pidx(pa), .is_zero(za));
  winreg_map #(.NWIN(NWIN), .GRP(GRP), .LIDX_W(LIDX_W), .WIN_W(WIN_W), .PIDX_W(PIDX_W))
    u_map_b (.lidx(rd_b_idx), .win(cwp), .pidx(pb), .is_zero(zb));
  winreg_map #(.NWIN(NWIN), .GRP(GRP), .LIDX_W(LIDX_W), .WIN_W(WIN_W), .PIDX_W(PIDX_W))
    u_map_w (.lidx(wr_idx), .win(cwp), .pidx(pw), .is_zero(zw));

  winreg_array #(.DATA_W(DATA_W), .NPHYS(NPHYS), .PIDX_W(PIDX_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(pa), .ra_zero(za), .ra_data(rd_a_data),
    .rb_idx(pb), .rb_zero(zb), .rb_data(rd_b_data),
    .we(wr_en && !zw), .w_idx(pw), .w_data(wr_data)
  );
endmodule

// File: rtl/winreg_chk.sv
module winreg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWIN   = 8,
  parameter int unsigned LIDX_W = 5,
  parameter int unsigned WIN_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LIDX_W-1:0] rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [LIDX_W-1:0] rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              save_req,
  input logic              restore_req,
  input logic              mask_wr_en,
  input logic [NWIN-1:0]   mask_wr_data,
  input logic [WIN_W-1:0]  cwp,
  input logic [NWIN-1:0]   wim,
  input logic              trap_ovf,
  input logic              trap_unf
);
  logic [NWIN-1:0]  eff;
  logic [WIN_W-1:0] dn, up;
  assign eff = mask_wr_en ? mask_wr_data : wim;
  assign dn  = (cwp == '0) ? WIN_W'(NWIN - 1) : cwp - 1'b1;
  assign up  = (cwp == WIN_W'(NWIN - 1)) ? '0 : cwp + 1'b1;

  p_zero_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_a_idx == '0 |-> rd_a_data == '0);
  p_zero_b_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_b_idx == '0 |-> rd_b_data == '0);
  p_save_move_r6: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && !eff[dn] |=> cwp == $past(dn) && !trap_ovf);
  p_restore_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req && restore_req && !eff[up] |=> cwp == $past(up) && !trap_unf);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req && !restore_req |=> $stable(cwp) && !trap_ovf && !trap_unf);
  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    save_req && eff[dn] |=> trap_ovf && $stable(cwp));
  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !save_req && restore_req && eff[up] |=> trap_unf && $stable(cwp));
  p_one_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_ovf, trap_unf}));
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_en |=> wim == $past(mask_wr_data));
  p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_en |=> $stable(wim));
endmodule

bind winreg_file winreg_chk #(.DATA_W(DATA_W), .NWIN(NWIN), .LIDX_W(LIDX_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
  .save_req(save_req), .restore_req(restore_req),
  .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
  .cwp(cwp), .wim(wim), .trap_ovf(trap_ovf), .trap_unf(trap_unf)
);

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
  logic        clk, rst_n;
  logic [7:0]  mask_init;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data;
  logic        wr_en, save_req, restore_req, mask_wr_en;
  logic [7:0]  mask_wr_data;
  logic [2:0]  cwp;
  logic [7:0]  wim;
  logic        trap_ovf, trap_unf;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  winreg_file u0 (
    .clk(clk), .rst_n(rst_n), .mask_init(mask_init),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .cwp(cwp), .wim(wim), .trap_ovf(trap_ovf), .trap_unf(trap_unf)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // vector: op[41:40] (0 write, 1 read both ports, 2 save, 3 restore),
  //         idx[39:35], data[34:3] (write data or expected read), cwp[2:0] expected after op
  localparam int NV = 16;
  localparam logic [41:0] VEC [NV] = '{
    {2'd0, 5'd1,  32'h1111_1111, 3'd0},   // R3 global
    {2'd0, 5'd16, 32'h0000_00A0, 3'd0},   // local w0
    {2'd0, 5'd8,  32'h0000_00B0, 3'd0},   // out w0
    {2'd0, 5'd24, 32'h0000_00C0, 3'd0},   // in w0
    {2'd2, 5'd0,  32'h0,         3'd7},   // R6 save wraps 0->7
    {2'd1, 5'd24, 32'h0000_00B0, 3'd7},   // R5 callee ins = caller outs
    {2'd1, 5'd16, 32'h0,         3'd7},   // R4 locals private
    {2'd1, 5'd1,  32'h1111_1111, 3'd7},   // R3 global shared
    {2'd0, 5'd16, 32'h0000_00A7, 3'd7},
    {2'd3, 5'd0,  32'h0,         3'd0},   // R6 restore wraps 7->0
    {2'd1, 5'd16, 32'h0000_00A0, 3'd0},   // R4
    {2'd1, 5'd8,  32'h0000_00B0, 3'd0},   // R5
    {2'd1, 5'd24, 32'h0000_00C0, 3'd0},
    {2'd3, 5'd0,  32'h0,         3'd1},   // R6 restore
    {2'd1, 5'd8,  32'h0000_00C0, 3'd1},   // R5 outs of w1 = ins of w0
    {2'd1, 5'd24, 32'h0,         3'd1}    // R5 ins of w1 untouched group
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; save_req = 0; restore_req = 0; mask_wr_en = 0;
  endtask

  // drive at negedge, pass one rising edge, return 2 ns after it
  task automatic step(input bit sv, input bit rs, input bit mwe, input logic [7:0] mwd,
                      input bit we, input logic [4:0] wi, input logic [31:0] wd);
    @(negedge clk);
    save_req = sv; restore_req = rs; mask_wr_en = mwe; mask_wr_data = mwd;
    wr_en = we; wr_idx = wi; wr_data = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic read2(input logic [4:0] a, input logic [4:0] b,
                       output logic [31:0] da, output logic [31:0] db);
    @(negedge clk);
    idle_inputs();
    rd_a_idx = a; rd_b_idx = b;
    #3;
    da = rd_a_data; db = rd_b_data;
  endtask

  initial begin
    logic [31:0] da, db;
    rst_n = 0; mask_init = 8'h10; mask_wr_data = 0;
    rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
    idle_inputs();
    repeat (3) @(posedge clk);
    #3;
    check("R1 cwp in reset", {29'd0, cwp}, 32'd0);
    check("R1 mask in reset", {24'd0, wim}, 32'h10);
    @(negedge clk);
    rst_n = 1;
    @(posedge clk); #2;
    check("R1 traps after reset", {30'd0, trap_ovf, trap_unf}, 32'd0);
    read2(5'd5, 5'd20, da, db);
    check("R1 global clear", da, 32'd0);
    check("R1 local clear", db, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  ix;
      logic [31:0] dv;
      logic [2:0]  ec;
      {op, ix, dv, ec} = VEC[i];
      case (op)
        2'd0: step(0, 0, 0, 8'h00, 1, ix, dv);
        2'd1: begin
          read2(ix, ix, da, db);
          check($sformatf("R5/R4/R3 vec %0d port A", i), da, dv);
          check($sformatf("R12 vec %0d port B", i), db, dv);
        end
        2'd2: step(1, 0, 0, 8'h00, 0, 0, 0);
        default: step(0, 1, 0, 8'h00, 0, 0, 0);
      endcase
      if (op >= 2) check($sformatf("R6 vec %0d cwp", i), {29'd0, cwp}, {29'd0, ec});
    end

    // R6 / R8: climb to 3, then restore into invalid window 4
    step(0, 1, 0, 8'h00, 0, 0, 0);
    step(0, 1, 0, 8'h00, 0, 0, 0);
    check("R6 cwp after two restores", {29'd0, cwp}, 32'd3);
    step(0, 1, 0, 8'h00, 0, 0, 0);
    check("R8 underflow flag", {31'd0, trap_unf}, 32'd1);
    check("R8 cwp held", {29'd0, cwp}, 32'd3);
    check("R8 no overflow", {31'd0, trap_ovf}, 32'd0);
    step(0, 0, 0, 8'h00, 0, 0, 0);
    check("R8 flag one cycle", {31'd0, trap_unf}, 32'd0);

    // R10 mask load, R7 overflow
    step(0, 0, 1, 8'h04, 0, 0, 0);
    check("R10 mask loaded", {24'd0, wim}, 32'h04);
    step(1, 0, 0, 8'h00, 0, 0, 0);
    check("R7 overflow flag", {31'd0, trap_ovf}, 32'd1);
    check("R7 cwp held", {29'd0, cwp}, 32'd3);
    step(0, 0, 0, 8'h00, 0, 0, 0);
    check("R7 flag one cycle", {31'd0, trap_ovf}, 32'd0);
    step(1, 0, 1, 8'h00, 0, 0, 0);
    check("R10 new mask governs save", {29'd0, cwp}, 32'd2);
    check("R10 no stale trap", {31'd0, trap_ovf}, 32'd0);
    check("R10 mask cleared", {24'd0, wim}, 32'h00);

    // R9 both requests
    step(1, 1, 0, 8'h00, 0, 0, 0);
    check("R9 save wins", {29'd0, cwp}, 32'd1);
    step(1, 0, 0, 8'h00, 0, 0, 0);
    check("R6 save to 0", {29'd0, cwp}, 32'd0);

    // R11 write with save in same cycle lands in old window
    step(1, 0, 0, 8'h00, 1, 5'd16, 32'h0000_005A);
    check("R11 cwp moved", {29'd0, cwp}, 32'd7);
    read2(5'd16, 5'd1, da, db);
    check("R11 new window local untouched", da, 32'h0000_00A7);
    step(0, 1, 0, 8'h00, 0, 0, 0);
    read2(5'd16, 5'd16, da, db);
    check("R11 old window got write", da, 32'h0000_005A);

    // R2 register zero
    step(0, 0, 0, 8'h00, 1, 5'd0, 32'hFFFF_FFFF);
    read2(5'd0, 5'd0, da, db);
    check("R2 port A zero", da, 32'd0);
    check("R2 port B zero", db, 32'd0);

    // R12 independent ports
    read2(5'd1, 5'd24, da, db);
    check("R12 port A global", da, 32'h1111_1111);
    check("R12 port B in", db, 32'h0000_00C0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule